// File: doc/BRIEF.md
# Backlight PWM Generator with Linear Pre-Divider and Power-of-Two Counter

This block produces a backlight pulse-width waveform from a fixed reference clock. The length of one PWM period is the product of two settings: an 8-bit linear pre-divider F, and a counter length of 2^Pn steps. The prescaler counts F reference cycles for each step. The period counter takes 2^Pn steps. So one period lasts F × 2^Pn reference cycles, and the output frequency is the reference frequency divided by that product. A duty level sets how many counter steps of each period the output stays high.

Configuration arrives over a small register write port. Writes to four addresses set the divider, the exponent, the duty level, and an enable bit for frequency control. Two plain inputs give the device's allowed exponent range. Settings that fall outside their legal range are clamped, never rejected. All written values pass through a shadow stage and take effect only at the next period boundary, so the waveform never shows a shortened or stretched pulse.

Top module: `bl_pwm_gen`

## Requirements
- R1: With frequency control enabled, the output repeats every F × 2^Pn clock cycles, where F and Pn are the effective (clamped) settings.
- R2: F is taken from bits 7:0 of a write to address 0; upper data bits are ignored, and a stored F of 0 acts as F = 1.
- R3: Pn is taken from bits 4:0 of a write to address 1; data bits above bit 4 are ignored.
- R4: An exponent below `pn_min_i` is raised to `pn_min_i`, and one above `pn_max_i` is lowered to `pn_max_i`.
- R5: Bit 0 of address 3 enables frequency control. While it is 0, the stored F and Pn have no effect, and the period uses F = 1 and Pn = `pn_max_i`.
- R6: The duty level L is written at address 2 (CNT_W+1 bits, full scale 2^CNT_W). The counter value is left-aligned to CNT_W bits and compared with L, and the output is high while the aligned value is below L. The high time per period is therefore F × min(ceil(L / 2^(CNT_W−Pn)), 2^Pn) cycles, and high time comes first in each period.
- R7: A level of 0 gives a constant low output.
- R8: A level with bit CNT_W set (full scale or above) gives a constant high output.
- R9: Writes change nothing in the period that is running. New F, Pn and level are loaded only when a period ends, so the period in progress keeps its old length.
- R10: A synchronous active-high reset clears the counters and all settings. The output stays low during reset, and stays low after reset until a nonzero level is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 divider, 1 exponent, 2 level, 3 control |
| wr_data_i | input | CNT_W+1 | Register write data |
| pn_min_i | input | 5 | Lowest exponent the device supports |
| pn_max_i | input | 5 | Highest exponent the device supports |
| pwm_o | output | 1 | Registered PWM output |

## Verification
The assertions assume three things about the capability inputs: `pn_min_i` never exceeds `pn_max_i`, `pn_max_i` never exceeds CNT_W, and both stay steady while a period is loaded. Under these assumptions every exponent loaded into the shadow stage lies inside the device range. The stimulus draws `pn_min_i` from 0..2 and `pn_max_i` from `pn_min_i`..6, so they always keep that order. Both change only between measurements. F is kept small in the random draws so that each settle-and-measure window stays short. Directed cases cover divider 0, divider 255, an out-of-range exponent, a disabled enable bit, zero and full-scale levels, and a write made in the middle of a period.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int DIV_W = 8;
  localparam int EXP_W = 5;

  typedef enum logic [1:0] {
    ADDR_DIV = 2'd0,
    ADDR_EXP = 2'd1,
    ADDR_LVL = 2'd2,
    ADDR_CTL = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int LVL_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [LVL_W-1:0] wr_data_i,
  output logic [DIV_W-1:0] div_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic             en_o
);
  reg_addr_e addr;
  assign addr = reg_addr_e'(wr_addr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_o <= '0;
      exp_o <= '0;
      lvl_o <= '0;
      en_o  <= 1'b0;
    end else if (wr_en_i) begin
      case (addr)
        ADDR_DIV: div_o <= wr_data_i[DIV_W-1:0];
        ADDR_EXP: exp_o <= wr_data_i[EXP_W-1:0];
        ADDR_LVL: lvl_o <= wr_data_i;
        ADDR_CTL: en_o  <= wr_data_i[0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/bl_pwm_sel.sv
module bl_pwm_sel
  import bl_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [EXP_W-1:0] pn_min_i,
  input  logic [EXP_W-1:0] pn_max_i,
  output logic [DIV_W-1:0] div_o,
  output logic [EXP_W-1:0] exp_o
);
  localparam logic [EXP_W-1:0] CEIL = EXP_W'(CNT_W);

  logic [EXP_W-1:0] top_lim;
  logic [EXP_W-1:0] bounded;

  always_comb begin
    top_lim = (pn_max_i > CEIL) ? CEIL : pn_max_i;
    bounded = exp_i;
    if (bounded < pn_min_i) bounded = pn_min_i;
    if (bounded > top_lim)  bounded = top_lim;
    if (en_i) begin
      div_o = (div_i == '0) ? DIV_W'(1) : div_i;
      exp_o = bounded;
    end else begin
      div_o = DIV_W'(1);
      exp_o = top_lim;
    end
  end
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
  import bl_pwm_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int LVL_W = CNT_W + 1,
  localparam int SH_W  = $clog2(CNT_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] nxt_div_i,
  input  logic [EXP_W-1:0] nxt_exp_i,
  input  logic [LVL_W-1:0] nxt_lvl_i,
  output logic             pwm_o,
  output logic             period_end_o,
  output logic [DIV_W-1:0] act_div_o,
  output logic [EXP_W-1:0] act_exp_o,
  output logic [LVL_W-1:0] act_lvl_o
);
  logic [DIV_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   one_sh;
  logic [CNT_W-1:0] last_val;
  logic [SH_W-1:0]  sh;
  logic [CNT_W-1:0] aligned;
  logic             step;
  logic             hi_d;

  always_comb begin
    one_sh       = (CNT_W+1)'(1) << act_exp_o;
    last_val     = CNT_W'(one_sh - 1'b1);
    sh           = SH_W'(CNT_W) - SH_W'(act_exp_o);
    aligned      = cnt_q << sh;
    step         = (pre_q == act_div_o - 1'b1);
    period_end_o = step && (cnt_q == last_val);
    hi_d         = ({1'b0, aligned} < act_lvl_o);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q     <= '0;
      cnt_q     <= '0;
      act_div_o <= DIV_W'(1);
      act_exp_o <= '0;
      act_lvl_o <= '0;
      pwm_o     <= 1'b0;
    end else begin
      pwm_o <= hi_d;
      if (period_end_o) begin
        pre_q     <= '0;
        cnt_q     <= '0;
        act_div_o <= nxt_div_i;
        act_exp_o <= nxt_exp_i;
        act_lvl_o <= nxt_lvl_i;
      end else if (step) begin
        pre_q <= '0;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen
  import bl_pwm_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int LVL_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [LVL_W-1:0] wr_data_i,
  input  logic [4:0]       pn_min_i,
  input  logic [4:0]       pn_max_i,
  output logic             pwm_o
);
  logic [DIV_W-1:0] reg_div, sel_div, act_div;
  logic [EXP_W-1:0] reg_exp, sel_exp, act_exp;
  logic [LVL_W-1:0] reg_lvl, act_lvl;
  logic             reg_en;
  logic             period_end;

  bl_pwm_regs #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .div_o(reg_div), .exp_o(reg_exp),
    .lvl_o(reg_lvl), .en_o(reg_en)
  );

  bl_pwm_sel #(.CNT_W(CNT_W)) sel_i (
    .en_i(reg_en), .div_i(reg_div), .exp_i(reg_exp),
    .pn_min_i(pn_min_i), .pn_max_i(pn_max_i),
    .div_o(sel_div), .exp_o(sel_exp)
  );

  bl_pwm_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst(rst), .nxt_div_i(sel_div), .nxt_exp_i(sel_exp),
    .nxt_lvl_i(reg_lvl), .pwm_o(pwm_o), .period_end_o(period_end),
    .act_div_o(act_div), .act_exp_o(act_exp), .act_lvl_o(act_lvl)
  );
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk #(
  parameter int CNT_W = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           pwm_o,
  input logic           period_end,
  input logic [7:0]     act_div,
  input logic [4:0]     act_exp,
  input logic [CNT_W:0] act_lvl,
  input logic [4:0]     pn_min_i,
  input logic [4:0]     pn_max_i
);
  // R10
  rst_low_chk: assert property (@(posedge clk) rst |=> !pwm_o);

  // R2
  div_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    act_div != 8'd0);

  // R4
  exp_bound_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_exp) |-> (act_exp >= pn_min_i && act_exp <= pn_max_i));

  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !period_end |=> ($stable(act_div) && $stable(act_exp) && $stable(act_lvl)));

  // R7
  zero_low_chk: assert property (@(posedge clk) disable iff (rst)
    (act_lvl == '0) |=> !pwm_o);

  // R8
  full_high_chk: assert property (@(posedge clk) disable iff (rst)
    act_lvl[CNT_W] |=> pwm_o);
endmodule

bind bl_pwm_gen bl_pwm_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .pwm_o(pwm_o), .period_end(period_end),
  .act_div(act_div), .act_exp(act_exp), .act_lvl(act_lvl),
  .pn_min_i(pn_min_i), .pn_max_i(pn_max_i)
);

// File: tb/bl_pwm_gen_tb_top.sv
module bl_pwm_gen_tb_top;
  localparam int W = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [W:0]  wr_data = '0;
  logic [4:0]  pn_min = 5'd0;
  logic [4:0]  pn_max = 5'd4;
  logic        pwm;

  int checks = 0;
  int errors = 0;
  int prev_per = 1;
  int cyc = 0;

  bl_pwm_gen #(.CNT_W(W)) dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pn_min_i(pn_min), .pn_max_i(pn_max), .pwm_o(pwm)
  );

  always #5 clk = ~clk;

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      report();
    end
  end

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [W:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int eff_f(bit en, int freg);
    int f;
    if (!en) return 1;
    f = freg & 255;
    return (f == 0) ? 1 : f;
  endfunction

  function automatic int eff_pn(bit en, int preg, int mn, int mx);
    int p;
    if (!en) return mx;
    p = preg & 31;
    if (p < mn) p = mn;
    if (p > mx) p = mx;
    return p;
  endfunction

  function automatic int exp_hi(int f, int p, int lvl);
    int s, steps;
    s = W - p;
    steps = (lvl + (1 << s) - 1) >> s;
    if (steps > (1 << p)) steps = 1 << p;
    return steps * f;
  endfunction

  task automatic wait_rise(int lim, output bit found);
    bit prv, cur;
    found = 0;
    prv = pwm;
    for (int i = 0; i < lim && !found; i++) begin
      @(negedge clk);
      cur = pwm;
      if (!prv && cur) found = 1;
      prv = cur;
    end
  endtask

  task automatic measure(string req, int per, int hi);
    bit found;
    int cnt_hi, bad;
    if (hi == 0 || hi == per) begin
      bad = 0;
      for (int i = 0; i < 2 * per + 4; i++) begin
        @(negedge clk);
        if (pwm != (hi != 0)) bad++;
      end
      chk(req, bad, 0);
      return;
    end
    wait_rise(2 * per + 4, found);
    chk(req, int'(found), 1);
    if (!found) return;
    cnt_hi = 0;
    for (int i = 0; i < per; i++) begin
      if (pwm) cnt_hi++;
      @(negedge clk);
    end
    chk(req, cnt_hi, hi);
    chk(req, int'(pwm), 1);
  endtask

  task automatic run_cfg(string req, bit en, int freg, int preg, int lvl);
    int f, p, per;
    wr(2'd0, (W+1)'(freg));
    wr(2'd1, (W+1)'(preg));
    wr(2'd2, (W+1)'(lvl));
    wr(2'd3, (W+1)'(en));
    f = eff_f(en, freg);
    p = eff_pn(en, preg, pn_min, pn_max);
    per = f * (1 << p);
    repeat (prev_per + per + 4) @(negedge clk);
    measure(req, per, exp_hi(f, p, lvl));
    prev_per = per;
  endtask

  initial begin
    int bad;
    bit found;
    int d1, d2;
    void'($urandom(1234));
    // R10: output low during reset
    bad = 0;
    repeat (4) begin
      @(negedge clk);
      if (pwm) bad++;
    end
    chk("R10", bad, 0);
    @(negedge clk); rst = 1'b0;
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (pwm) bad++;
    end
    chk("R10", bad, 0);
    prev_per = 16;

    // R1 R6 basic enabled setting
    run_cfg("R1_R6", 1'b1, 3, 2, 1 << 15);
    // R2: F of 0 behaves as 1, upper data bits ignored
    run_cfg("R2", 1'b1, 32'h100, 3, 3 << 14);
    // R2: F of 255 in full
    pn_min = 0; pn_max = 2;
    run_cfg("R2", 1'b1, 255, 2, 1 << 15);
    pn_max = 5;
    // R3: bits above 4 of the exponent are ignored
    run_cfg("R3", 1'b1, 2, 32'h1E3, 1 << 15);
    // R4: exponent above max lowered, below min raised
    pn_min = 2; pn_max = 4;
    run_cfg("R4", 1'b1, 2, 9, 5 << 13);
    run_cfg("R4", 1'b1, 2, 0, 1 << 15);
    // R5: enable off, stored divider and exponent unused
    run_cfg("R5", 1'b0, 7, 2, 1 << 15);
    // R7 / R8: constant levels
    run_cfg("R7", 1'b1, 3, 3, 0);
    run_cfg("R8", 1'b1, 3, 3, 1 << 16);
    // R6: level just below full scale with fine rounding
    run_cfg("R6", 1'b1, 1, 3, (1 << 16) - 1);
    run_cfg("R6", 1'b1, 4, 3, 1);

    // R9: write mid-period, running period keeps its length
    pn_min = 0; pn_max = 5;
    run_cfg("R9", 1'b1, 3, 3, 1 << 15);
    wait_rise(60, found);
    chk("R9", int'(found), 1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 17'd5;
    @(negedge clk); wr_en = 1'b0;
    d1 = 2;
    wait_rise(200, found);
    d1 = 0;
    chk("R9", int'(found), 1);
    d2 = 0;
    found = 0;
    begin
      bit prv;
      prv = pwm;
      for (int i = 0; i < 200 && !found; i++) begin
        @(negedge clk);
        d2++;
        if (!prv && pwm) found = 1;
        prv = pwm;
      end
    end
    chk("R9", d2, 40);
    prev_per = 40;

    // R1 R4 R5 R6: random mix
    for (int t = 0; t < 25; t++) begin
      int fr, pr, lv, sel;
      bit en;
      pn_min = 5'($urandom_range(0, 2));
      pn_max = 5'($urandom_range(int'(pn_min), 6));
      fr = $urandom_range(0, 12) | ($urandom_range(0, 1) << 9);
      pr = $urandom_range(0, 31) | ($urandom_range(0, 3) << 6);
      sel = $urandom_range(0, 9);
      lv = (sel == 0) ? 0 : (sel == 1) ? (1 << 16) : $urandom_range(0, (1 << 17) - 1);
      en = ($urandom_range(0, 4) != 0);
      run_cfg("R1_R4_R5_R6", en, fr, pr, lv);
    end
    report();
  end
endmodule